// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns the memory requests of an 8-bit controller core into external bus cycles. Each bus cycle takes twelve oscillator clocks. One port carries the low address byte first and then data, and a second port carries the high address byte. Five control outputs are produced: an address-latch strobe, an active-low program-store strobe, an active-low read strobe, an active-low write strobe and an enable for the shared port's output drivers. A twelve-step phase counter sets every strobe edge, so the pulse widths and the gaps between strobes are fixed numbers of clocks.

The core sees a one-clock `req_take` window at the end of each cycle. A request held there is taken at the next edge and runs as the following bus cycle. The request can be an instruction fetch, a data read or a data write. Fetches go to an on-chip program store or to the external bus, depending on a strap input and the fetch address. For data cycles, the high address byte comes either from the request address or from the port latch value. The fetched or read byte is returned during the last clock of the cycle.

Top module: `xbus_seq`

## Requirements
- R1: While reset is held, `ale` is 0, `pstb_n`, `rd_n` and `wr_n` are 1, `ad_oe` is 0, `rsp_valid` is 0 and `req_take` is 0.
- R2: A bus cycle has twelve clocks, numbered phase 0 to phase 11. `req_take` is 1 only in phase 11. The request inputs are taken at the edge that ends phase 11 and govern the next cycle. `req_kind` 0 is a fetch, 1 a read and 2 a write. Code 3, or `req_valid` at 0, gives an idle cycle.
- R3: In an external cycle, `ale` is 1 in phases 0 and 1 only, which is two clocks. The low address byte is driven on `ad_out`, with `ad_oe` at 1, in phases 0 to 2. The address is therefore valid before `ale` falls and held for one clock after it falls.
- R4: In an external fetch, `pstb_n` is 0 in phases 3 to 5. It falls one clock after `ale` falls and stays low for three clocks. `ad_oe` is 0 from phase 3 to phase 11.
- R5: In a read, `rd_n` is 0 in phases 5 to 10, which is six clocks starting three clocks after `ale` falls. `ad_oe` is 0 from phase 3 on. `pstb_n` and `wr_n` stay 1 for the whole cycle.
- R6: In a write, `wr_n` is 0 in phases 5 to 10. The write byte is on `ad_out` with `ad_oe` at 1 in phases 3 to 11, so it appears before `wr_n` falls and is held one clock after `wr_n` rises. `pstb_n` stays 1.
- R7: A fetch is internal when `int_rom_en` is 1 and the address is below 4096. An internal fetch produces no `ale`, no strobe and no drive, and it returns `rom_byte`. All other fetches are external. Reads and writes are always external.
- R8: In an external fetch, `a_hi` carries address bits 15:8 in all twelve phases. In a data cycle, `a_hi` carries `p2_latch` when `req_hi_latch` is 1 and address bits 15:8 otherwise. In idle and internal cycles, `a_hi` carries `p2_latch`. The first fetch after a data cycle again shows its own address high byte.
- R9: The returned byte is `ad_in` sampled in phase 5 for an external fetch, `ad_in` sampled in phase 10 for a read, and `rom_byte` for an internal fetch. `rsp_valid` is 1 for exactly one clock, in phase 11, with `rsp_data` holding that byte. It stays 0 for writes and idle cycles.
- R10: An idle cycle produces no `ale`, no strobe, no drive and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_take | output | 1 | High in phase 11, when a request is accepted |
| req_valid | input | 1 | A request is present |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 none |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| req_hi_latch | input | 1 | Data cycle takes its high byte from `p2_latch` |
| p2_latch | input | 8 | High-port latch value |
| int_rom_en | input | 1 | Strap: low 4096 fetch addresses are on chip |
| rom_byte | input | 8 | Byte from the on-chip program store |
| ad_out | output | 8 | Shared low address / data output |
| ad_oe | output | 8 | Output enable of the shared port (all bits equal) |
| ad_in | input | 8 | Shared port input |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe |
| pstb_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| rsp_valid | output | 1 | Returned byte valid |
| rsp_data | output | 8 | Returned byte |

## Verification
A request given in phase 11 takes effect at the next edge. Every output then follows the phase number, because each output is registered from the next-phase value. The bench drives a request in the negative-edge window where `req_take` is 1. It then records twelve samples, one at each falling edge, and sample k is phase k. Strobe bit patterns, address and data bytes and the high byte are compared per phase against vectors built from the phase windows in the requirements. The response is checked at sample 11. The bus model returns the memory byte only while a strobe is low, so sampling one clock too late returns a different value.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int NPH  = 12;
  localparam int PH_W = $clog2(NPH);

  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2,
    K_NONE  = 2'd3
  } kind_e;

  localparam logic [PH_W-1:0] PH_LAST    = PH_W'(NPH - 1);
  localparam logic [PH_W-1:0] PH_RESET   = PH_W'(NPH - 2);
  localparam logic [PH_W-1:0] PH_ALE_END = PH_W'(1);
  localparam logic [PH_W-1:0] PH_ADR_END = PH_W'(2);
  localparam logic [PH_W-1:0] PH_PS_BEG  = PH_W'(3);
  localparam logic [PH_W-1:0] PH_PS_END  = PH_W'(5);
  localparam logic [PH_W-1:0] PH_RW_BEG  = PH_W'(5);
  localparam logic [PH_W-1:0] PH_RW_END  = PH_W'(10);
  localparam logic [PH_W-1:0] PH_WD_BEG  = PH_W'(3);
endpackage

// File: rtl/xbus_phase.sv
module xbus_phase
  import xbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] ph,
  output logic [PH_W-1:0] ph_nxt,
  output logic            last
);
  always_comb begin
    last   = (ph == PH_LAST);
    ph_nxt = last ? '0 : ph + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_RESET;
    else     ph <= ph_nxt;
  end

  p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
    ph <= PH_LAST);
  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    last |=> (ph == '0));
endmodule

// File: rtl/xbus_drive.sv
module xbus_drive
  import xbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] ph_nxt,
  input  logic            n_ext,
  input  kind_e           n_kind,
  input  logic [AW-1:0]   n_addr,
  input  logic [DW-1:0]   n_wdata,
  input  logic [AW-DW-1:0] n_hi,
  input  logic [AW-DW-1:0] p2_latch,
  output logic            ale,
  output logic            pstb_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic            ad_oe,
  output logic [DW-1:0]   ad_out,
  output logic [AW-DW-1:0] a_hi
);
  logic in_ale, in_adr, in_ps, in_rw, in_wd;

  always_comb begin
    in_ale = (ph_nxt <= PH_ALE_END);
    in_adr = (ph_nxt <= PH_ADR_END);
    in_ps  = (ph_nxt >= PH_PS_BEG) && (ph_nxt <= PH_PS_END);
    in_rw  = (ph_nxt >= PH_RW_BEG) && (ph_nxt <= PH_RW_END);
    in_wd  = (ph_nxt >= PH_WD_BEG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= 1'b0;
      pstb_n <= 1'b1;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      ad_oe  <= 1'b0;
      ad_out <= '0;
      a_hi   <= '0;
    end else begin
      ale    <= n_ext && in_ale;
      pstb_n <= !(n_ext && (n_kind == K_FETCH) && in_ps);
      rd_n   <= !(n_ext && (n_kind == K_READ)  && in_rw);
      wr_n   <= !(n_ext && (n_kind == K_WRITE) && in_rw);
      ad_oe  <= n_ext && (in_adr || ((n_kind == K_WRITE) && in_wd));
      ad_out <= in_adr ? n_addr[DW-1:0] : n_wdata;
      a_hi   <= n_ext ? n_hi : p2_latch;
    end
  end

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $countones({~pstb_n, ~rd_n, ~wr_n}) <= 1);
  p_ale_two_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> $past(ale, 2));
  p_ale_drive_r3: assert property (@(posedge clk) disable iff (rst)
    ale |-> ad_oe);
  p_ps_float_r4: assert property (@(posedge clk) disable iff (rst)
    !pstb_n |-> !ad_oe);
  p_rd_float_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);
  p_wr_drive_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe);
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
  import xbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] ph,
  input  logic            c_vld,
  input  logic            c_ext,
  input  kind_e           c_kind,
  input  logic [DW-1:0]   ad_in,
  input  logic [DW-1:0]   rom_byte,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data
);
  logic is_fetch, is_read;

  always_comb begin
    is_fetch = c_vld && (c_kind == K_FETCH);
    is_read  = c_vld && (c_kind == K_READ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= (is_fetch || is_read) && (ph == PH_RESET);
      if (is_fetch && (ph == PH_PS_END))
        rsp_data <= c_ext ? ad_in : rom_byte;
      else if (is_read && (ph == PH_RW_END))
        rsp_data <= ad_in;
    end
  end

  p_rsp_single_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 16,
  parameter int ROM_LIMIT = 4096
) (
  input  logic          clk,
  input  logic          rst,
  output logic          req_take,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_hi_latch,
  input  logic [AW-DW-1:0] p2_latch,
  input  logic          int_rom_en,
  input  logic [DW-1:0] rom_byte,
  output logic [DW-1:0] ad_out,
  output logic [DW-1:0] ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [AW-DW-1:0] a_hi,
  output logic          ale,
  output logic          pstb_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  localparam int HW = AW - DW;

  logic [PH_W-1:0] ph, ph_nxt;
  logic            last;
  logic            oe_bit;

  // current cycle descriptor
  logic            c_vld, c_ext;
  kind_e           c_kind;
  logic [AW-1:0]   c_addr;
  logic [DW-1:0]   c_wdata;
  logic [HW-1:0]   c_hi;

  // descriptor of the request on the inputs, and of the next clock
  logic            r_vld, r_ext;
  kind_e           r_kind;
  logic [HW-1:0]   r_hi;
  logic            n_ext;
  kind_e           n_kind;
  logic [AW-1:0]   n_addr;
  logic [DW-1:0]   n_wdata;
  logic [HW-1:0]   n_hi;

  xbus_phase u_phase (
    .clk(clk), .rst(rst), .ph(ph), .ph_nxt(ph_nxt), .last(last)
  );

  always_comb begin
    r_kind = kind_e'(req_kind);
    r_vld  = req_valid && (r_kind != K_NONE);
    r_ext  = r_vld && ((r_kind != K_FETCH) || !int_rom_en ||
                       (32'(req_addr) >= ROM_LIMIT));
    r_hi   = ((r_kind != K_FETCH) && req_hi_latch) ? p2_latch
                                                    : req_addr[AW-1:DW];
    n_ext   = last ? r_ext     : c_ext;
    n_kind  = last ? r_kind    : c_kind;
    n_addr  = last ? req_addr  : c_addr;
    n_wdata = last ? req_wdata : c_wdata;
    n_hi    = last ? r_hi      : c_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_vld   <= 1'b0;
      c_ext   <= 1'b0;
      c_kind  <= K_NONE;
      c_addr  <= '0;
      c_wdata <= '0;
      c_hi    <= '0;
    end else if (last) begin
      c_vld   <= r_vld;
      c_ext   <= r_ext;
      c_kind  <= r_kind;
      c_addr  <= req_addr;
      c_wdata <= req_wdata;
      c_hi    <= r_hi;
    end
  end

  xbus_drive #(.DW(DW), .AW(AW)) u_drive (
    .clk(clk), .rst(rst), .ph_nxt(ph_nxt),
    .n_ext(n_ext), .n_kind(n_kind), .n_addr(n_addr),
    .n_wdata(n_wdata), .n_hi(n_hi), .p2_latch(p2_latch),
    .ale(ale), .pstb_n(pstb_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_oe(oe_bit), .ad_out(ad_out), .a_hi(a_hi)
  );

  assign ad_oe = {DW{oe_bit}};

  xbus_capture #(.DW(DW)) u_capture (
    .clk(clk), .rst(rst), .ph(ph),
    .c_vld(c_vld), .c_ext(c_ext), .c_kind(c_kind),
    .ad_in(ad_in), .rom_byte(rom_byte),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign req_take = last;

  p_rsp_at_end_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_take);
  p_int_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (c_vld && !c_ext) |-> (pstb_n && !ale));
endmodule

// File: tb/tb_xbus_seq.sv
module tb_xbus_seq;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_take, req_valid, req_hi_latch, int_rom_en;
  logic [1:0] req_kind;
  logic [15:0] req_addr;
  logic [7:0] req_wdata, p2_latch, rom_byte, ad_out, ad_oe, ad_in, a_hi;
  logic       ale, pstb_n, rd_n, wr_n, rsp_valid;
  logic [7:0] rsp_data;
  logic [7:0] mem_byte;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  // bus model: memory answers only while a strobe is low
  assign ad_in = (!pstb_n || !rd_n) ? mem_byte : 8'hEE;

  xbus_seq dut (
    .clk(clk), .rst(rst), .req_take(req_take), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_hi_latch(req_hi_latch), .p2_latch(p2_latch),
    .int_rom_en(int_rom_en), .rom_byte(rom_byte),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi),
    .ale(ale), .pstb_n(pstb_n), .rd_n(rd_n), .wr_n(wr_n),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // one bus cycle; entered at a falling edge inside phase 11
  task automatic run_cycle(input string tag, input logic v,
      input logic [1:0] kd, input logic [15:0] ad, input logic [7:0] wd,
      input logic hs, input logic en, input logic [7:0] p2,
      input logic [7:0] mem, input logic [7:0] rom);
    logic [11:0] ale_v, ps_v, rd_v, wr_v, oe_v, tk_v, rv_v;
    logic [11:0] e_ale, e_ps, e_rd, e_wr, e_oe;
    logic ext, isf, isr, isw, bad_ad, bad_hi;
    logic [7:0] e_hi, act_ad, exp_ad, act_hi, e_rsp;
    chk({tag, " R2 req_take at entry"}, req_take, 1'b1);
    req_valid = v; req_kind = kd; req_addr = ad; req_wdata = wd;
    req_hi_latch = hs; int_rom_en = en; p2_latch = p2;
    mem_byte = mem; rom_byte = rom;
    isf = (kd == 2'd0); isr = (kd == 2'd1); isw = (kd == 2'd2);
    ext = v && (isr || isw || (isf && (!en || ad >= 16'd4096)));
    e_hi = (ext && !(hs && !isf)) ? ad[15:8] : p2;
    bad_ad = 1'b0; bad_hi = 1'b0;
    act_ad = 8'h00; exp_ad = 8'h00; act_hi = 8'h00;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      ale_v[k] = ale;     ps_v[k] = ~pstb_n; rd_v[k] = ~rd_n;
      wr_v[k]  = ~wr_n;   oe_v[k] = ad_oe[0] & (&ad_oe);
      tk_v[k]  = req_take; rv_v[k] = rsp_valid;
      e_ale[k] = ext && (k <= 1);
      e_ps[k]  = ext && isf && (k >= 3) && (k <= 5);
      e_rd[k]  = ext && isr && (k >= 5) && (k <= 10);
      e_wr[k]  = ext && isw && (k >= 5) && (k <= 10);
      e_oe[k]  = ext && ((k <= 2) || (isw && k >= 3));
      if (e_oe[k] && !bad_ad) begin
        if (ad_out !== ((k <= 2) ? ad[7:0] : wd)) begin
          bad_ad = 1'b1; act_ad = ad_out;
          exp_ad = (k <= 2) ? ad[7:0] : wd;
        end
      end
      if (a_hi !== e_hi && !bad_hi) begin
        bad_hi = 1'b1; act_hi = a_hi;
      end
    end
    chk({tag, " R2 req_take phases"}, tk_v, 12'h800);
    chk({tag, " R3 ale phases"}, ale_v, e_ale);
    chk({tag, " R4 pstb phases"}, ps_v, e_ps);
    chk({tag, " R5 rd phases"}, rd_v, e_rd);
    chk({tag, " R6 wr phases"}, wr_v, e_wr);
    chk({tag, " R3/R6 ad_oe phases"}, oe_v, e_oe);
    chk({tag, " R3 R6 ad_out bytes"}, bad_ad ? act_ad : exp_ad, exp_ad);
    chk({tag, " R8 a_hi"}, bad_hi ? act_hi : e_hi, e_hi);
    chk({tag, " R9 rsp_valid phases"}, rv_v,
        (v && (isf || isr)) ? 12'h800 : 12'h000);
    if (v && (isf || isr)) begin
      e_rsp = (isf && !ext) ? rom : mem;
      chk({tag, " R9 rsp_data"}, rsp_data, e_rsp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; req_valid = 1'b0; req_kind = 2'd3; req_addr = '0;
    req_wdata = '0; req_hi_latch = 1'b0; int_rom_en = 1'b0;
    p2_latch = 8'hFF; rom_byte = '0; mem_byte = '0;
    repeat (3) @(negedge clk);
    chk("R1 ale in reset", ale, 1'b0);
    chk("R1 strobes in reset", {pstb_n, rd_n, wr_n}, 3'b111);
    chk("R1 ad_oe in reset", ad_oe, 8'h00);
    chk("R1 rsp_valid/req_take in reset", {rsp_valid, req_take}, 2'b00);
    rst = 1'b0;
    while (!req_take) @(negedge clk);
  endtask

  task automatic t_fetch_ext();   // R7 strap low: low address goes out
    run_cycle("R7 fetch strap low", 1'b1, 2'd0, 16'h0123, 8'h00, 1'b0,
              1'b0, 8'hFF, 8'h5A, 8'h11);
  endtask
  task automatic t_fetch_int();   // R7 last internal address
    run_cycle("R7 fetch internal 0FFF", 1'b1, 2'd0, 16'h0FFF, 8'h00, 1'b0,
              1'b1, 8'h77, 8'h5A, 8'hC3);
  endtask
  task automatic t_fetch_edge();  // R7 first external address
    run_cycle("R7 fetch 1000", 1'b1, 2'd0, 16'h1000, 8'h00, 1'b0,
              1'b1, 8'h77, 8'h96, 8'hC3);
  endtask
  task automatic t_read_ptr();    // R5 R8 high byte from address
    run_cycle("R5 read pointer", 1'b1, 2'd1, 16'h8A55, 8'h00, 1'b0,
              1'b0, 8'h3C, 8'h4E, 8'h00);
  endtask
  task automatic t_read_latch();  // R8 high byte from latch
    run_cycle("R8 read latch", 1'b1, 2'd1, 16'h8A56, 8'h00, 1'b1,
              1'b0, 8'h3C, 8'hB1, 8'h00);
  endtask
  task automatic t_write();       // R6
    run_cycle("R6 write", 1'b1, 2'd2, 16'h4321, 8'hA7, 1'b0,
              1'b0, 8'h3C, 8'h00, 8'h00);
  endtask
  task automatic t_fetch_after(); // R8 restore after data cycle
    run_cycle("R8 fetch after data", 1'b1, 2'd0, 16'h12F0, 8'h00, 1'b0,
              1'b0, 8'h3C, 8'h2D, 8'h00);
  endtask
  task automatic t_idle();        // R10
    run_cycle("R10 idle", 1'b0, 2'd0, 16'h2222, 8'h00, 1'b0,
              1'b0, 8'h99, 8'h00, 8'h00);
    run_cycle("R10 code 3", 1'b1, 2'd3, 16'h3333, 8'h00, 1'b0,
              1'b0, 8'h98, 8'h00, 8'h00);
  endtask

  initial begin
    t_reset();
    t_fetch_ext();
    t_fetch_int();
    t_fetch_edge();
    t_read_ptr();
    t_read_latch();
    t_write();
    t_fetch_after();
    t_idle();
    t_write();
    t_read_latch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 20000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule